// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block brings an SDR or DDR SDRAM device from power-on to an operational state. A mode pin, captured while reset is held, picks which of two command scripts one shared engine walks through. The engine drives a small command bus made of a clock-enable, a 2-bit command code, a bank address and a row address. It counts every mandatory wait in controller clocks, and it takes the mode-register contents from configuration inputs.

Once the last mode register has been written, the block raises `refresh_enable` so that an external periodic refresh timer can start. It then waits for a long settling interval and raises `init_done`. Both flags stay high until the next reset. A reset applied at any point restarts the whole sequence from the power-up wait.

All waits given in microseconds are converted to clock counts through `CYC_PER_US`, so a test build can shrink them by lowering that value. The block has no data stream: every pin is a plain level-type control or status signal with no handshake.

Top module: `dram_powerup_seq`

## Requirements
- R1: `ddr_mode` is sampled on every clock edge while `rst_n` is low. The value taken at the last reset edge picks the script (1 = DDR, 0 = SDR), and later changes of `ddr_mode` have no effect until the next reset.
- R2: From reset onward, `cke` is low and the command is NOP for a power-up wait of `SDR_PWRUP_US*CYC_PER_US` clocks (SDR) or `DDR_PWRUP_US*CYC_PER_US` clocks (DDR). After that wait, `cke` rises together with a NOP cycle and then stays high, and no non-NOP command ever appears while `cke` is low.
- R3: The command codes are NOP = 0, PRECHARGE ALL = 1, AUTO REFRESH = 2 and LOAD MODE = 3. PRECHARGE ALL drives address bit 10 high with all other address bits and `ba` at zero. AUTO REFRESH drives `ba` and the address at zero.
- R4: The SDR script is PRECHARGE ALL, AUTO REFRESH, AUTO REFRESH, then LOAD MODE with `ba`=0 and address `mr0_val` with bit 8 forced low.
- R5: The DDR script is as follows. First comes PRECHARGE ALL. Then come LOAD MODE with `ba`=3 (`emr3_val`), `ba`=2 (`emr2_val`), `ba`=1 (`emr1_val`), and `ba`=0 with address `mr0_val` having bit 8 (DLL reset) forced high. After that come PRECHARGE ALL, two AUTO REFRESH commands, and a final LOAD MODE with `ba`=0 and `mr0_val` with bit 8 forced low.
- R6: Every command lasts exactly one clock, with NOPs between commands. The first command follows the rise of `cke` by `T_CKE` clocks. Each later command follows the one before it by `T_RP` after PRECHARGE ALL, by `T_RFC` after AUTO REFRESH, and by `T_MRD` after LOAD MODE. The exception is the DLL-reset load, after which the gap is `T_MRD+DLL_IDLE`.
- R7: `refresh_enable` rises `T_MRD` clocks after the final LOAD MODE, and no command other than NOP is issued while it is high.
- R8: `init_done` rises `SETTLE_US*CYC_PER_US` clocks after `refresh_enable`. Both stay high until reset, and both are low during reset.
- R9: A reset in mid-sequence returns the outputs to the reset state (`cke` low, NOP, flags low), and the next release replays the full script from the power-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ddr_mode | input | 1 | Script select, captured during reset (1 = DDR) |
| mr0_val | input | ADDR_W | Base mode register contents |
| emr1_val | input | ADDR_W | Extended mode register 1 contents |
| emr2_val | input | ADDR_W | Extended mode register 2 contents |
| emr3_val | input | ADDR_W | Extended mode register 3 contents |
| cke | output | 1 | Device clock enable |
| cmd | output | 2 | Command code (see R3) |
| ba | output | 2 | Bank address / mode register target |
| addr | output | ADDR_W | Row address / mode register value |
| refresh_enable | output | 1 | Periodic refresh may run |
| init_done | output | 1 | Initialization complete |

## Verification
The bench checks the DLL-reset bit in both directions by using `mr0_val` values that have bit 8 set and values that have it clear. A design that only ORs the bit in, or never clears it, would leave the DLL in reset after the final load. It flips `ddr_mode` right after reset release, so a design that reads the pin live would run the wrong script and issue the wrong number of commands. Every command's cycle is compared with an expected timeline, which exposes an off-by-one in any gap, especially the long idle after the DLL-reset load. It also cuts a DDR run short with a reset halfway through, which catches a sequencer that keeps its step index or clock-enable across reset.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_PREA = 2'd1,
    CMD_AREF = 2'd2,
    CMD_LMR  = 2'd3
  } dram_cmd_e;

  typedef enum logic [2:0] {
    SRC_ZERO, SRC_A10, SRC_MR0, SRC_MR0_DLL, SRC_EMR1, SRC_EMR2, SRC_EMR3
  } addr_src_e;

  typedef enum logic [2:0] {
    GAP_PWR, GAP_CKE, GAP_RP, GAP_RFC, GAP_MRD, GAP_DLL
  } gap_e;

  typedef struct packed {
    dram_cmd_e cmd;
    logic [1:0] ba;
    addr_src_e  src;
    gap_e       gap;
    logic       last;
  } init_step_t;

  localparam int STEP_IDX_W    = 4;
  localparam int DLL_RESET_BIT = 8;
  localparam int PREA_ALL_BIT  = 10;

  function automatic init_step_t mk_step(dram_cmd_e c, logic [1:0] b, addr_src_e s, gap_e g, logic l);
    init_step_t st;
    st.cmd = c; st.ba = b; st.src = s; st.gap = g; st.last = l;
    return st;
  endfunction

  // Short script: power-up wait, clock enable, precharge, two refreshes, base mode load.
  function automatic init_step_t sdr_step(logic [STEP_IDX_W-1:0] i);
    case (i)
      4'd0:    return mk_step(CMD_NOP,  2'd0, SRC_ZERO, GAP_PWR, 1'b0);
      4'd1:    return mk_step(CMD_NOP,  2'd0, SRC_ZERO, GAP_CKE, 1'b0);
      4'd2:    return mk_step(CMD_PREA, 2'd0, SRC_A10,  GAP_RP,  1'b0);
      4'd3:    return mk_step(CMD_AREF, 2'd0, SRC_ZERO, GAP_RFC, 1'b0);
      4'd4:    return mk_step(CMD_AREF, 2'd0, SRC_ZERO, GAP_RFC, 1'b0);
      default: return mk_step(CMD_LMR,  2'd0, SRC_MR0,  GAP_MRD, 1'b1);
    endcase
  endfunction

  // Long script: extended registers high to low, DLL-reset load, idle, second round.
  function automatic init_step_t ddr_step(logic [STEP_IDX_W-1:0] i);
    case (i)
      4'd0:    return mk_step(CMD_NOP,  2'd0, SRC_ZERO,    GAP_PWR, 1'b0);
      4'd1:    return mk_step(CMD_NOP,  2'd0, SRC_ZERO,    GAP_CKE, 1'b0);
      4'd2:    return mk_step(CMD_PREA, 2'd0, SRC_A10,     GAP_RP,  1'b0);
      4'd3:    return mk_step(CMD_LMR,  2'd3, SRC_EMR3,    GAP_MRD, 1'b0);
      4'd4:    return mk_step(CMD_LMR,  2'd2, SRC_EMR2,    GAP_MRD, 1'b0);
      4'd5:    return mk_step(CMD_LMR,  2'd1, SRC_EMR1,    GAP_MRD, 1'b0);
      4'd6:    return mk_step(CMD_LMR,  2'd0, SRC_MR0_DLL, GAP_DLL, 1'b0);
      4'd7:    return mk_step(CMD_PREA, 2'd0, SRC_A10,     GAP_RP,  1'b0);
      4'd8:    return mk_step(CMD_AREF, 2'd0, SRC_ZERO,    GAP_RFC, 1'b0);
      4'd9:    return mk_step(CMD_AREF, 2'd0, SRC_ZERO,    GAP_RFC, 1'b0);
      default: return mk_step(CMD_LMR,  2'd0, SRC_MR0,     GAP_MRD, 1'b1);
    endcase
  endfunction

endpackage

// File: rtl/dram_wait_timer.sv
module dram_wait_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] last_cnt,
  output logic             hit
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == last_cnt);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= last_cnt); // R6

endmodule

// File: rtl/dram_init_script.sv
module dram_init_script
  import dram_init_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int CNT_W        = 16,
  parameter int CYC_PER_US   = 250,
  parameter int SDR_PWRUP_US = 100,
  parameter int DDR_PWRUP_US = 200,
  parameter int T_CKE        = 4,
  parameter int T_RP         = 4,
  parameter int T_RFC        = 20,
  parameter int T_MRD        = 2,
  parameter int DLL_IDLE     = 200
) (
  input  logic                  ddr,
  input  logic [STEP_IDX_W-1:0] idx,
  input  logic [ADDR_W-1:0]     mr0_val,
  input  logic [ADDR_W-1:0]     emr1_val,
  input  logic [ADDR_W-1:0]     emr2_val,
  input  logic [ADDR_W-1:0]     emr3_val,
  output dram_cmd_e             step_cmd,
  output logic [1:0]            step_ba,
  output logic [ADDR_W-1:0]     step_addr,
  output logic                  step_last,
  output logic [CNT_W-1:0]      step_last_cnt
);
  localparam int PWR_SDR = SDR_PWRUP_US * CYC_PER_US;
  localparam int PWR_DDR = DDR_PWRUP_US * CYC_PER_US;
  localparam int GAP_DLL_CYC = T_MRD + DLL_IDLE;
  localparam logic [ADDR_W-1:0] DLL_MASK  = ADDR_W'(1) << DLL_RESET_BIT;
  localparam logic [ADDR_W-1:0] PREA_MASK = ADDR_W'(1) << PREA_ALL_BIT;

  init_step_t st;

  assign st = ddr ? ddr_step(idx) : sdr_step(idx);

  assign step_cmd  = st.cmd;
  assign step_ba   = st.ba;
  assign step_last = st.last;

  always_comb begin
    unique case (st.src)
      SRC_A10:     step_addr = PREA_MASK;
      SRC_MR0:     step_addr = mr0_val & ~DLL_MASK;
      SRC_MR0_DLL: step_addr = mr0_val | DLL_MASK;
      SRC_EMR1:    step_addr = emr1_val;
      SRC_EMR2:    step_addr = emr2_val;
      SRC_EMR3:    step_addr = emr3_val;
      default:     step_addr = '0;
    endcase
  end

  always_comb begin
    unique case (st.gap)
      GAP_PWR: step_last_cnt = ddr ? CNT_W'(PWR_DDR - 1) : CNT_W'(PWR_SDR - 1);
      GAP_CKE: step_last_cnt = CNT_W'(T_CKE - 1);
      GAP_RP:  step_last_cnt = CNT_W'(T_RP - 1);
      GAP_RFC: step_last_cnt = CNT_W'(T_RFC - 1);
      GAP_DLL: step_last_cnt = CNT_W'(GAP_DLL_CYC - 1);
      default: step_last_cnt = CNT_W'(T_MRD - 1);
    endcase
  end

endmodule

// File: rtl/dram_powerup_seq.sv
module dram_powerup_seq
  import dram_init_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int CYC_PER_US   = 250,
  parameter int SDR_PWRUP_US = 100,
  parameter int DDR_PWRUP_US = 200,
  parameter int SETTLE_US    = 1000,
  parameter int T_CKE        = 4,
  parameter int T_RP         = 4,
  parameter int T_RFC        = 20,
  parameter int T_MRD        = 2,
  parameter int DLL_IDLE     = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ddr_mode,
  input  logic [ADDR_W-1:0] mr0_val,
  input  logic [ADDR_W-1:0] emr1_val,
  input  logic [ADDR_W-1:0] emr2_val,
  input  logic [ADDR_W-1:0] emr3_val,
  output logic              cke,
  output logic [1:0]        cmd,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              refresh_enable,
  output logic              init_done
);
  localparam int SETTLE_CYC = SETTLE_US * CYC_PER_US;
  localparam int PWR_MAX    = ((DDR_PWRUP_US > SDR_PWRUP_US) ? DDR_PWRUP_US : SDR_PWRUP_US) * CYC_PER_US;
  localparam int GAP_MAX    = (T_MRD + DLL_IDLE > T_RFC) ? T_MRD + DLL_IDLE : T_RFC;
  localparam int WAIT_A     = (SETTLE_CYC > PWR_MAX) ? SETTLE_CYC : PWR_MAX;
  localparam int WAIT_MAX   = (WAIT_A > GAP_MAX) ? WAIT_A : GAP_MAX;
  localparam int CNT_W      = $clog2(WAIT_MAX + 1);

  typedef enum logic [1:0] {PH_RUN, PH_SETTLE, PH_DONE} phase_e;

  phase_e                  phase;
  logic                    ddr_q;
  logic                    first;
  logic [STEP_IDX_W-1:0]   idx;
  logic                    hit;
  logic [CNT_W-1:0]        last_cnt;
  dram_cmd_e               s_cmd;
  logic [1:0]              s_ba;
  logic [ADDR_W-1:0]       s_addr;
  logic                    s_last;
  logic [CNT_W-1:0]        s_last_cnt;

  dram_init_script #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CYC_PER_US(CYC_PER_US),
    .SDR_PWRUP_US(SDR_PWRUP_US), .DDR_PWRUP_US(DDR_PWRUP_US),
    .T_CKE(T_CKE), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD), .DLL_IDLE(DLL_IDLE)
  ) u_script (
    .ddr(ddr_q), .idx(idx),
    .mr0_val(mr0_val), .emr1_val(emr1_val), .emr2_val(emr2_val), .emr3_val(emr3_val),
    .step_cmd(s_cmd), .step_ba(s_ba), .step_addr(s_addr),
    .step_last(s_last), .step_last_cnt(s_last_cnt)
  );

  assign last_cnt = (phase == PH_SETTLE) ? CNT_W'(SETTLE_CYC - 1) : s_last_cnt;

  dram_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .clr(hit || (phase == PH_DONE)),
    .last_cnt(last_cnt), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ddr_q <= ddr_mode;
      idx   <= '0;
      first <= 1'b1;
      phase <= PH_RUN;
    end else begin
      unique case (phase)
        PH_RUN: begin
          first <= hit && !s_last;
          if (hit) begin
            if (s_last) phase <= PH_SETTLE;
            else        idx   <= idx + 1'b1;
          end
        end
        PH_SETTLE: if (hit) phase <= PH_DONE;
        default: ;
      endcase
    end
  end

  logic issue;
  assign issue          = (phase == PH_RUN) && first;
  assign cke            = !((phase == PH_RUN) && (idx == '0));
  assign cmd            = issue ? s_cmd  : CMD_NOP;
  assign ba             = issue ? s_ba   : 2'd0;
  assign addr           = issue ? s_addr : '0;
  assign refresh_enable = (phase != PH_RUN);
  assign init_done      = (phase == PH_DONE);

  AST_MODE_HELD:     assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> $stable(ddr_q)); // R1
  AST_CKE_STAYS:     assert property (@(posedge clk) disable iff (!rst_n) cke |=> cke); // R2
  AST_CMD_NEEDS_CKE: assert property (@(posedge clk) disable iff (!rst_n) (cmd != CMD_NOP) |-> cke); // R2
  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) (cmd != CMD_NOP) |=> (cmd == CMD_NOP)); // R6
  AST_QUIET_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n) refresh_enable |-> (cmd == CMD_NOP)); // R7
  AST_DONE_STICKY:   assert property (@(posedge clk) disable iff (!rst_n) init_done |=> (init_done && refresh_enable)); // R8
  AST_DONE_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n) $rose(init_done) |-> $past(refresh_enable)); // R8

endmodule

// File: tb/dram_powerup_seq_test.sv
module dram_powerup_seq_test;
  localparam int AW = 13, CPU = 1, SDR_US = 100, DDR_US = 200, SET_US = 50;
  localparam int TCKE = 4, TRP = 3, TRFC = 5, TMRD = 2, DLLI = 20;
  localparam logic [AW-1:0] DLLB = 13'h0100;
  localparam logic [AW-1:0] A10  = 13'h0400;

  logic clk = 1'b0, rst_n = 1'b0, ddr_mode = 1'b0;
  logic [AW-1:0] mr0 = '0, e1 = '0, e2 = '0, e3 = '0;
  logic cke, ref_en, done;
  logic [1:0] cmd, ba;
  logic [AW-1:0] addr;

  always #2 clk = ~clk;

  dram_powerup_seq #(
    .ADDR_W(AW), .CYC_PER_US(CPU), .SDR_PWRUP_US(SDR_US), .DDR_PWRUP_US(DDR_US),
    .SETTLE_US(SET_US), .T_CKE(TCKE), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD), .DLL_IDLE(DLLI)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ddr_mode(ddr_mode),
    .mr0_val(mr0), .emr1_val(e1), .emr2_val(e2), .emr3_val(e3),
    .cke(cke), .cmd(cmd), .ba(ba), .addr(addr),
    .refresh_enable(ref_en), .init_done(done)
  );

  int n_run = 0, n_fail = 0;
  int k, n_ev, cke_k, ref_k, done_k;
  int ev_t[16]; logic [1:0] ev_cmd[16]; logic [1:0] ev_ba[16]; logic [AW-1:0] ev_addr[16];
  int n_exp, bt, x_cke, x_ref, x_done;
  int xt[16]; logic [1:0] xc[16]; logic [1:0] xb[16]; logic [AW-1:0] xa[16];

  // Monitor: sample index k counts clocks since reset release.
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd != 2'd0) begin
        if (n_ev < 16) begin
          ev_t[n_ev] = k; ev_cmd[n_ev] = cmd; ev_ba[n_ev] = ba; ev_addr[n_ev] = addr;
        end
        n_ev++;
      end
      if (cke && cke_k < 0) cke_k = k;
      if (ref_en && ref_k < 0) ref_k = k;
      if (done && done_k < 0) done_k = k;
      k++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] c, input logic [1:0] b, input logic [AW-1:0] a, input int gap);
    xt[n_exp] = bt; xc[n_exp] = c; xb[n_exp] = b; xa[n_exp] = a;
    n_exp++; bt += gap;
  endtask

  // Expected timeline derived from the requirements R2 to R8.
  task automatic build_exp(input bit ddr, input logic [AW-1:0] m0, a1, a2, a3);
    n_exp = 0;
    bt = (ddr ? DDR_US : SDR_US) * CPU;
    x_cke = bt; bt += TCKE;
    push(2'd1, 2'd0, A10, TRP);
    if (ddr) begin
      push(2'd3, 2'd3, a3, TMRD);
      push(2'd3, 2'd2, a2, TMRD);
      push(2'd3, 2'd1, a1, TMRD);
      push(2'd3, 2'd0, m0 | DLLB, TMRD + DLLI);
      push(2'd1, 2'd0, A10, TRP);
    end
    push(2'd2, 2'd0, '0, TRFC);
    push(2'd2, 2'd0, '0, TRFC);
    push(2'd3, 2'd0, m0 & ~DLLB, TMRD);
    x_ref = bt - 0;
    x_done = x_ref + SET_US * CPU;
  endtask

  task automatic do_reset(input bit ddr, input logic [AW-1:0] m0, a1, a2, a3);
    rst_n = 1'b0; ddr_mode = ddr; mr0 = m0; e1 = a1; e2 = a2; e3 = a3;
    repeat (3) @(posedge clk);
    #1;
    // R9 / R8 / R2: reset state at the ports
    chk(cke == 1'b0 && cmd == 2'd0 && ref_en == 1'b0 && done == 1'b0, "R9", "reset state cke/cmd/ref/done",
        {cke, cmd, ref_en, done}, 0);
    n_ev = 0; k = 0; cke_k = -1; ref_k = -1; done_k = -1;
  endtask

  task automatic run_one(input bit ddr, input bit flip, input logic [AW-1:0] m0, a1, a2, a3, input string tag);
    int w;
    do_reset(ddr, m0, a1, a2, a3);
    rst_n = 1'b1;
    if (flip) ddr_mode = ~ddr;   // R1: change after capture must not matter
    build_exp(ddr, m0, a1, a2, a3);
    w = 0;
    while (done_k < 0 && w < 3000) begin @(posedge clk); w++; end
    repeat (4) @(posedge clk);
    #1;
    chk(cke_k == x_cke, "R2", "cke rise cycle", cke_k, x_cke);
    chk(n_ev == n_exp, tag, "command count", n_ev, n_exp);
    for (int i = 0; i < n_exp && i < n_ev; i++) begin
      chk(ev_cmd[i] == xc[i] && ev_ba[i] == xb[i] && ev_addr[i] == xa[i],
          (xc[i] == 2'd3) ? (ddr ? "R5" : "R4") : "R3", "command/ba/addr",
          {ev_cmd[i], ev_ba[i], ev_addr[i]}, {xc[i], xb[i], xa[i]});
      chk(ev_t[i] == xt[i], "R6", "command cycle", ev_t[i], xt[i]);
    end
    chk(ref_k == x_ref, "R7", "refresh enable cycle", ref_k, x_ref);
    chk(done_k == x_done, "R8", "done cycle", done_k, x_done);
    chk(done == 1'b1 && ref_en == 1'b1 && cmd == 2'd0, "R8", "flags held", {done, ref_en, cmd}, 4'b1100);
  endtask

  initial begin
    int seed;
    seed = $urandom(20240611);
    // Directed: SDR with DLL bit set in config (R4 clears it)
    run_one(1'b0, 1'b0, 13'h0133, 13'h0, 13'h0, 13'h0, "R4");
    // Directed: DDR with DLL bit clear, distinct EMR values (R5)
    run_one(1'b1, 1'b0, 13'h0032, 13'h0044, 13'h1A00, 13'h0005, "R5");
    // R1: mode flipped after release, both directions
    run_one(1'b1, 1'b1, 13'h1F3F, 13'h0001, 13'h0002, 13'h0003, "R1");
    run_one(1'b0, 1'b1, 13'h0022, 13'h0011, 13'h0012, 13'h0013, "R1");
    // R9: interrupt a DDR run in the middle of its mode loads, then replay
    do_reset(1'b1, 13'h0055, 13'h0066, 13'h0077, 13'h0088);
    rst_n = 1'b1;
    repeat (DDR_US * CPU + 12) @(posedge clk);
    run_one(1'b1, 1'b0, 13'h0055, 13'h0066, 13'h0077, 13'h0088, "R9");
    // Random mix
    for (int r = 0; r < 8; r++) begin
      bit d;
      d = 1'($urandom);
      run_one(d, 1'($urandom), AW'($urandom), AW'($urandom), AW'($urandom), AW'($urandom), d ? "R5" : "R4");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule